// File: doc/BRIEF.md
# ADC Conversion and Calibration Sequencer

This block is the control side of a successive-approximation converter. It runs from the master clock and turns two asynchronous request pins into timed operations. A falling edge on the active-low convert request starts a conversion. A rising edge on the calibration request starts one of three calibration sequences, picked by a 2-bit select input. While an operation runs, `busy` stays high for the exact number of master-clock cycles set for that operation. When the count ends, `busy` falls.

In the first cycle that `busy` is low again, the block gives a one-cycle `done` pulse and a 2-bit code that names the finished operation. Both request pins pass through a two-flop synchronizer and then an edge detector. This puts `busy` high two cycles after the first clock edge that samples the request, which is inside the start-latency budget for calibration. Requests that arrive while an operation runs are dropped. If both requests arrive together, the conversion wins.

The analog sampling, the DAC, the comparator and the calibration arithmetic are not part of this block. Only their timing frame is modelled.

Top module: `conv_cal_seq`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `done_code` is 2'b00.
- R2: A falling edge on `conv_start_n` starts a conversion. Let edge 0 be the first rising clock edge that samples the pin low. `busy` is still low after clock edge 1 and is high after clock edge 2. A rising edge on `conv_start_n` starts nothing.
- R3: A conversion keeps `busy` high for exactly LEN_CONV cycles (default 18) and finishes with `done_code` 2'b00.
- R4: A rising edge on `cal_start` with `cal_sel` 2'b00, 2'b01 or 2'b10 starts a calibration. The latency is the same as in R2: `busy` is low after clock edge 1 and high after clock edge 2, counted from the first clock edge that samples the pin high.
- R5: The calibration select values give these lengths and finish codes. Select 2'b00 is the full self-calibration: LEN_FULL cycles (default 125013), code 2'b01. Select 2'b01 is the DAC plus system full-scale calibration: LEN_DAC cycles (default 111114), code 2'b10. Select 2'b10 is the system offset calibration: LEN_OFFS cycles (default 13899), code 2'b11.
- R6: A calibration request with `cal_sel` 2'b11 is ignored. `busy` stays low and no `done` pulse occurs.
- R7: Any convert or calibration edge that arrives while `busy` is high is dropped, not queued. The running operation keeps its length, and no operation follows it.
- R8: `cal_sel` is sampled only when a calibration is accepted. Changing it while `busy` is high does not change the length or the finish code.
- R9: If a convert edge and a calibration edge are detected in the same idle cycle, the conversion runs and the calibration request is dropped.
- R10: `done` is high for exactly one cycle: the first cycle in which `busy` is low after an operation. `done_code` names that operation and holds its value until the next operation finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Asynchronous active-low convert request; a falling edge starts a conversion |
| cal_start | input | 1 | Asynchronous calibration request; a rising edge starts a calibration |
| cal_sel | input | 2 | Calibration select, sampled when a calibration is accepted |
| busy | output | 1 | High for the whole of a conversion or calibration |
| done | output | 1 | One-cycle pulse when an operation finishes |
| done_code | output | 2 | Code of the last operation that finished |

## Verification
Most internal faults show up at the ports as a wrong `busy` length. A bad counter load or a bad select decode changes the length at once, and the length is off from the first operation. A wrong latched operation gives the wrong `done_code` on the very next `done` pulse. A failure to drop requests shows up within a few cycles of the falling `busy` edge, as a second `busy` interval or an extra `done`. A synchronizer or edge-detect fault moves the `busy` rise away from its two-cycle slot, so the first request after reset already exposes it.

// File: rtl/cseq_pkg.sv
// Package: shared types and helpers for the conversion/calibration sequencer.
// Assumes: operation codes are the values seen on done_code.
package cseq_pkg;

    // Finished-operation codes, as presented on done_code
    typedef enum logic [1:0] {
        OP_CONV     = 2'b00,
        OP_CAL_FULL = 2'b01,
        OP_CAL_DAC  = 2'b10,
        OP_CAL_OFFS = 2'b11
    } op_e;

    // Calibration select encodings on cal_sel
    localparam logic [1:0] SEL_FULL = 2'b00;
    localparam logic [1:0] SEL_DAC  = 2'b01;
    localparam logic [1:0] SEL_OFFS = 2'b10;
    localparam logic [1:0] SEL_RSVD = 2'b11;

    // Largest of four operation lengths, used to size the counter
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cseq_edge_detect.sv
// Module: cseq_edge_detect
// Synchronizes one asynchronous pin through STAGES flops, then gives a
// one-cycle pulse on the selected edge of the synchronized value.
// Assumes: the pin is held for at least one clock period, so that every
// level it takes is sampled. IDLE_LEVEL is the level the pin rests at, and it
// is loaded in reset so that no edge is seen when reset ends.
module cseq_edge_detect #(
    parameter int unsigned STAGES     = 2,
    parameter bit          FALLING    = 1'b0,
    parameter bit          IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    assign level = sync_q[LAST];

    // Synchronizer chain: shift the pin in at the low end
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= IDLE_LEVEL;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= {STAGES{IDLE_LEVEL}};
                else        sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= level;
    end

    // Pick the edge polarity
    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~level;
        end else begin : g_rise
            assign pulse = level & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/cseq_arbiter.sv
// Module: cseq_arbiter
// Combinational request arbitration. While idle, a convert edge wins over a
// calibration edge. A calibration edge is accepted only for a defined select
// value. While busy, every edge is dropped.
// Assumes: the edge inputs are single-cycle pulses from cseq_edge_detect.
module cseq_arbiter
    import cseq_pkg::*;
(
    input  logic       busy,
    input  logic       conv_edge,
    input  logic       cal_edge,
    input  logic [1:0] cal_sel,
    output logic       start,
    output op_e        start_op
);

    // Decide whether to start an operation this cycle, and which one
    always_comb begin
        start    = 1'b0;
        start_op = OP_CONV;
        if (!busy) begin
            if (conv_edge) begin
                start    = 1'b1;
                start_op = OP_CONV;
            end else if (cal_edge) begin
                case (cal_sel)
                    SEL_FULL: begin
                        start    = 1'b1;
                        start_op = OP_CAL_FULL;
                    end
                    SEL_DAC: begin
                        start    = 1'b1;
                        start_op = OP_CAL_DAC;
                    end
                    SEL_OFFS: begin
                        start    = 1'b1;
                        start_op = OP_CAL_OFFS;
                    end
                    default: begin
                        start    = 1'b0;
                        start_op = OP_CONV;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cseq_op_timer.sv
// Module: cseq_op_timer
// Holds busy high for the length set for the accepted operation. It uses a
// down-counter that loads length-1 at the start, so busy is high for exactly
// "length" cycles. It then pulses done for one cycle and updates done_code.
// Assumes: start is asserted only while busy is low.
module cseq_op_timer
    import cseq_pkg::*;
#(
    parameter int unsigned LEN_CONV = 18,
    parameter int unsigned LEN_FULL = 125013,
    parameter int unsigned LEN_DAC  = 111114,
    parameter int unsigned LEN_OFFS = 13899
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_op,
    output logic busy,
    output logic done,
    output op_e  done_code,
    output op_e  run_op
);

    localparam int unsigned LEN_MAX = max_of4(LEN_CONV, LEN_FULL, LEN_DAC, LEN_OFFS);
    localparam int unsigned CW      = $clog2(LEN_MAX + 1);

    localparam logic [CW-1:0] LOAD_CONV = CW'(LEN_CONV - 1);
    localparam logic [CW-1:0] LOAD_FULL = CW'(LEN_FULL - 1);
    localparam logic [CW-1:0] LOAD_DAC  = CW'(LEN_DAC - 1);
    localparam logic [CW-1:0] LOAD_OFFS = CW'(LEN_OFFS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;
    logic          busy_q;
    logic          done_q;
    op_e           op_q;
    op_e           code_q;

    // Map the starting operation to its counter load value
    always_comb begin
        case (start_op)
            OP_CONV:     load_val = LOAD_CONV;
            OP_CAL_FULL: load_val = LOAD_FULL;
            OP_CAL_DAC:  load_val = LOAD_DAC;
            default:     load_val = LOAD_OFFS;
        endcase
    end

    // Busy interval: load on start, count down, finish at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_CONV;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= load_val;
                op_q   <= start_op;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Completion strobe and finished-operation code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= OP_CONV;
        end else begin
            done_q <= busy_q && (cnt_q == '0);
            if (busy_q && (cnt_q == '0)) code_q <= op_q;
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign done_code = code_q;
    assign run_op    = op_q;

endmodule

// File: rtl/conv_cal_seq.sv
// Module: conv_cal_seq (top)
// Conversion and calibration sequencer. It synchronizes the two request pins,
// detects their edges, picks one operation and times its busy interval.
// Assumes: the request pins are asynchronous to clk, and a convert request is
// held low for more than one clock period.
module conv_cal_seq
    import cseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LEN_CONV    = 18,
    parameter int unsigned LEN_FULL    = 125013,
    parameter int unsigned LEN_DAC     = 111114,
    parameter int unsigned LEN_OFFS    = 13899
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_start_n,
    input  logic       cal_start,
    input  logic [1:0] cal_sel,
    output logic       busy,
    output logic       done,
    output logic [1:0] done_code
);

    logic conv_edge;
    logic cal_edge;
    logic start;
    op_e  start_op;
    op_e  code_w;
    op_e  run_op;

    // Convert request: active low, start on the falling edge
    cseq_edge_detect #(
        .STAGES    (SYNC_STAGES),
        .FALLING   (1'b1),
        .IDLE_LEVEL(1'b1)
    ) u_conv_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (conv_start_n),
        .pulse(conv_edge)
    );

    // Calibration request: start on the rising edge
    cseq_edge_detect #(
        .STAGES    (SYNC_STAGES),
        .FALLING   (1'b0),
        .IDLE_LEVEL(1'b0)
    ) u_cal_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cal_start),
        .pulse(cal_edge)
    );

    cseq_arbiter u_arb (
        .busy     (busy),
        .conv_edge(conv_edge),
        .cal_edge (cal_edge),
        .cal_sel  (cal_sel),
        .start    (start),
        .start_op (start_op)
    );

    cseq_op_timer #(
        .LEN_CONV(LEN_CONV),
        .LEN_FULL(LEN_FULL),
        .LEN_DAC (LEN_DAC),
        .LEN_OFFS(LEN_OFFS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_op (start_op),
        .busy     (busy),
        .done     (done),
        .done_code(code_w),
        .run_op   (run_op)
    );

    assign done_code = code_w;

endmodule

// File: rtl/cseq_checker.sv
// Module: cseq_checker
// Assertion checker bound to conv_cal_seq. It measures each busy interval
// with its own counter and checks it against the length for the finish code.
module cseq_checker #(
    parameter int unsigned LEN_CONV = 18,
    parameter int unsigned LEN_FULL = 125013,
    parameter int unsigned LEN_DAC  = 111114,
    parameter int unsigned LEN_OFFS = 13899
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] done_code,
    input logic       start,
    input logic [1:0] run_op
);

    int unsigned run_len;

    // Count the busy-high cycles of the current interval
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= 0;
        else if (start) run_len <= 0;
        else if (busy)  run_len <= run_len + 1;
    end

    function automatic int unsigned len_for(input logic [1:0] code);
        case (code)
            2'b00:   return LEN_CONV;
            2'b01:   return LEN_FULL;
            2'b10:   return LEN_DAC;
            default: return LEN_OFFS;
        endcase
    endfunction

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done);                                          // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_len == len_for(done_code));                           // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));                                  // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R10
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(run_op));                        // R8
    AST_IDLE_NO_DONE_WITHOUT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !done);                                // R6

endmodule

bind conv_cal_seq cseq_checker #(
    .LEN_CONV(LEN_CONV),
    .LEN_FULL(LEN_FULL),
    .LEN_DAC (LEN_DAC),
    .LEN_OFFS(LEN_OFFS)
) u_cseq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .done_code(done_code),
    .start    (start),
    .run_op   (run_op)
);

// File: tb/conv_cal_seq_bench.sv
// Scoreboard bench: driver tasks push expected (code, length) items, and a
// monitor pops and compares them on every done pulse.
module conv_cal_seq_bench;

    localparam int unsigned T_LEN_CONV = 18;
    localparam int unsigned T_LEN_FULL = 301;
    localparam int unsigned T_LEN_DAC  = 222;
    localparam int unsigned T_LEN_OFFS = 139;

    typedef struct {
        logic [1:0] code;
        int         len;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start_n = 1'b1;
    logic       cal_start = 1'b0;
    logic [1:0] cal_sel = 2'b00;
    logic       busy;
    logic       done;
    logic [1:0] done_code;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    int  run_len  = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    conv_cal_seq #(
        .LEN_CONV(T_LEN_CONV),
        .LEN_FULL(T_LEN_FULL),
        .LEN_DAC (T_LEN_DAC),
        .LEN_OFFS(T_LEN_OFFS)
    ) u_conv_cal_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start_n(conv_start_n),
        .cal_start   (cal_start),
        .cal_sel     (cal_sel),
        .busy        (busy),
        .done        (done),
        .done_code   (done_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: measure busy intervals and compare against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) run_len++;
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(done_code == e.code, {e.tag, " done_code"}, done_code, e.code);
                    chk(run_len == e.len, {e.tag, " busy length"}, run_len, e.len);
                end
                run_len = 0;
            end
        end
    end

    // Latency check: inputs were driven just before this call at a negedge
    task automatic check_latency(input string tag);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, {tag, " busy early"}, busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, {tag, " busy rise"}, busy, 1);
    endtask

    task automatic do_conv();
        @(negedge clk);
        conv_start_n = 1'b0;
        sb_q.push_back('{2'b00, T_LEN_CONV, "R3 conversion"});
        check_latency("R2");
        repeat (2) @(negedge clk);
        conv_start_n = 1'b1;
    endtask

    task automatic do_cal(input logic [1:0] sel, input logic [1:0] code, input int len,
                          input string tag);
        @(negedge clk);
        cal_sel   = sel;
        cal_start = 1'b1;
        sb_q.push_back('{code, len, tag});
        check_latency("R4");
        repeat (2) @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_quiet(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, tag, {busy, done}, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(done_code == 2'b00, "R1 done_code", done_code, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Conversion, and the rising edge of the pin starts nothing
        do_conv();
        wait_idle();
        check_quiet(6, "R2 rising edge idle");
        chk(done_code == 2'b00, "R10 code held", done_code, 0);

        // Each calibration type
        do_cal(2'b00, 2'b01, T_LEN_FULL, "R5 full cal");
        wait_idle();
        do_cal(2'b01, 2'b10, T_LEN_DAC, "R5 dac cal");
        wait_idle();
        do_cal(2'b10, 2'b11, T_LEN_OFFS, "R5 offset cal");
        wait_idle();
        chk(done_code == 2'b11, "R10 code held", done_code, 3);

        // Reserved select is ignored
        @(negedge clk);
        cal_sel   = 2'b11;
        cal_start = 1'b1;
        check_quiet(4, "R6 reserved select");
        cal_start = 1'b0;
        check_quiet(8, "R6 reserved select");

        // Requests while busy are dropped; select change has no effect
        do_cal(2'b10, 2'b11, T_LEN_OFFS, "R8 offset cal");
        repeat (20) @(negedge clk);
        cal_sel      = 2'b00;
        conv_start_n = 1'b0;
        repeat (3) @(negedge clk);
        conv_start_n = 1'b1;
        cal_start    = 1'b1;
        repeat (3) @(negedge clk);
        cal_start    = 1'b0;
        chk(busy == 1'b1, "R7 still busy", busy, 1);
        wait_idle();
        check_quiet(10, "R7 dropped requests");

        // Simultaneous requests: conversion wins
        @(negedge clk);
        cal_sel      = 2'b01;
        conv_start_n = 1'b0;
        cal_start    = 1'b1;
        sb_q.push_back('{2'b00, T_LEN_CONV, "R9 simultaneous"});
        check_latency("R9");
        repeat (2) @(negedge clk);
        conv_start_n = 1'b1;
        cal_start    = 1'b0;
        wait_idle();
        check_quiet(10, "R9 cal dropped");

        // Back-to-back conversions
        do_conv();
        wait_idle();
        do_conv();
        wait_idle();

        chk(sb_q.size() == 0, "R10 pending done pulses", sb_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule